// File: doc/BRIEF.md
# Two-Level Least-Recently-Selected Switch Arbiter

This block decides, each cycle, which waiting packets a multi-port router may move through its switch. Arbitration is spread over two stages so that no single central arbiter sits on the critical path. In the first stage every input port runs its own small arbiter. It picks one ready request from the slots it holds, one slot per pairing of packet class and virtual channel, and offers that request as the port's nominee. In the second stage every output port runs an arbiter that looks at the nominees aimed at it and grants exactly one input port.

Both stages keep an ordered list of their requesters and favour the one that was served longest ago. An entry moves to the most-recent end of its list only when its grant takes effect. The output stage has two ways to rank competing nominees. In age mode the oldest packet wins. In class mode a fixed ranking of packet classes decides. In both modes, nominees that tie are settled by the output's own list. Grants and the per-slot accept signals are combinational from the current requests and the stored lists. The lists update on the rising clock edge.

Top module: `router_arb_top`

## Requirements
- R1: While `rstN` is low (synchronous, active low), every list returns to index order, with index 0 the least recently selected. On the first cycle after reset, each input nominates its lowest-numbered valid slot, and each output grants the lowest-numbered input that targets it (age mode, equal ages).
- R2: Slot `s` of input `i` sits at bit `i*8+s` of `reqValid`, where `s = class*2 + vc` (4 classes, 2 virtual channels). Its target sits at bits `[(i*8+s)*3 +: 3]` of `reqTarget` and its age at bits `[(i*8+s)*4 +: 4]` of `reqAge`. Each input nominates the valid slot that comes earliest in that input's local list.
- R3: A local list changes only when its nominee is granted, and the granted slot then moves to the most-recent end. A nominee that loses is offered again in the next cycle if its request is still present.
- R4: With `mode` = 0 (age mode), an output grants, among the inputs whose nominee targets it, the one whose nominee has the largest age.
- R5: With `mode` = 1 (class mode), an output grants the competing nominee with the highest class number (class = slot / 2). Class 3 ranks highest.
- R6: Ties on age or class go to the input that comes earliest in that output's global list. The granted input then moves to that list's most-recent end, and an output with no grant leaves its list unchanged.
- R7: `grant` bit `o*16+i` means output `o` grants input `i`. Each output grants at most one input per cycle.
- R8: Each input is granted by at most one output per cycle. `slotAccept` has exactly the granted input's nominee slot set, and is zero for inputs without a grant.
- R9: With no valid request, no grant or accept is issued and no list changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| mode | input | 1 | Output ranking: 0 age, 1 class |
| reqValid | input | 128 | Request present per input slot |
| reqTarget | input | 384 | Target output per input slot, 3 bits each |
| reqAge | input | 512 | Packet age per input slot, 4 bits each |
| grant | output | 112 | One-hot-or-zero grant per output, 16 bits per output |
| slotAccept | output | 128 | Accepted slot per input, one-hot-or-zero per input |

## Verification
The assertions assume that every valid request names an existing output, from 0 to 6, since a target of 7 matches no output arbiter. They also assume that `mode` and the request vectors are steady around the clock edge. The stimulus draws targets only from the legal range and changes inputs only on the falling edge. It covers fresh random traffic in both modes, uniform ages that force tie-breaking, long-lived requests that stay asserted until accepted so that losers must retry, and idle stretches.

// File: rtl/router_arb_pkg.sv
package router_arb_pkg;
  localparam int ARB_NUM_IN    = 16;
  localparam int ARB_NUM_OUT   = 7;
  localparam int ARB_NUM_CLASS = 4;
  localparam int ARB_NUM_VC    = 2;
  localparam int ARB_AGE_W     = 4;
  localparam int ARB_SLOTS     = ARB_NUM_CLASS * ARB_NUM_VC;
  localparam int ARB_SLOT_W    = $clog2(ARB_SLOTS);
  localparam int ARB_IN_W      = $clog2(ARB_NUM_IN);
  localparam int ARB_OUT_W     = $clog2(ARB_NUM_OUT);
  localparam int ARB_CLS_W     = $clog2(ARB_NUM_CLASS);
  localparam int ARB_KEY_W     = (ARB_AGE_W > ARB_CLS_W) ? ARB_AGE_W : ARB_CLS_W;

  typedef enum logic {ARB_AGE = 1'b0, ARB_CLASS = 1'b1} arb_mode_e;

  typedef struct packed {
    logic [ARB_NUM_IN-1:0]                 locUpd;
    logic [ARB_NUM_IN-1:0][ARB_SLOT_W-1:0] locSlot;
    logic [ARB_NUM_OUT-1:0]                gloUpd;
    logic [ARB_NUM_OUT-1:0][ARB_IN_W-1:0]  gloIdx;
  } arb_strobe_t;
endpackage

// File: rtl/router_arb_lrs_list.sv
module router_arb_lrs_list #(
  parameter int N = 8,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         updEn,
  input  logic [W-1:0] updIdx,
  output logic [N*W-1:0] order
);
  logic [W-1:0] entry     [N];
  logic [W-1:0] entryNext [N];

  always_comb begin
    int pos;
    pos = N - 1;
    for (int i = N - 1; i >= 0; i--) begin
      if (entry[i] == updIdx) pos = i;
    end
    for (int i = 0; i < N; i++) begin
      if (!updEn || i < pos) entryNext[i] = entry[i];
      else if (i == N - 1)   entryNext[i] = updIdx;
      else                   entryNext[i] = entry[i+1];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rstN) entry[i] <= W'(i);
      else       entry[i] <= entryNext[i];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign order[g*W +: W] = entry[g];
  end

  logic [N-1:0] present;
  always_comb begin
    present = '0;
    for (int i = 0; i < N; i++) present[entry[i]] = 1'b1;
  end

  AST_LRS_PERMUTATION: assert property (@(posedge clk) disable iff (!rstN)
    $countones(present) == N); // R1
  AST_LRS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updEn |=> $stable(order)); // R3
  AST_LRS_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    updEn |=> entry[N-1] == $past(updIdx)); // R3
endmodule

// File: rtl/router_arb_store.sv
module router_arb_store
  import router_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  arb_strobe_t strobe,
  output logic [ARB_NUM_IN*ARB_SLOTS*ARB_SLOT_W-1:0] locOrder,
  output logic [ARB_NUM_OUT*ARB_NUM_IN*ARB_IN_W-1:0] gloOrder
);
  localparam int LOC_BITS = ARB_SLOTS * ARB_SLOT_W;
  localparam int GLO_BITS = ARB_NUM_IN * ARB_IN_W;

  for (genvar i = 0; i < ARB_NUM_IN; i++) begin : g_loc
    router_arb_lrs_list #(.N(ARB_SLOTS), .W(ARB_SLOT_W)) list_i (
      .clk(clk), .rstN(rstN),
      .updEn(strobe.locUpd[i]), .updIdx(strobe.locSlot[i]),
      .order(locOrder[i*LOC_BITS +: LOC_BITS])
    );
  end

  for (genvar o = 0; o < ARB_NUM_OUT; o++) begin : g_glo
    router_arb_lrs_list #(.N(ARB_NUM_IN), .W(ARB_IN_W)) list_i (
      .clk(clk), .rstN(rstN),
      .updEn(strobe.gloUpd[o]), .updIdx(strobe.gloIdx[o]),
      .order(gloOrder[o*GLO_BITS +: GLO_BITS])
    );
  end
endmodule

// File: rtl/router_arb_ctrl.sv
module router_arb_ctrl
  import router_arb_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic mode,
  input  logic [ARB_NUM_IN*ARB_SLOTS-1:0]           reqValid,
  input  logic [ARB_NUM_IN*ARB_SLOTS*ARB_OUT_W-1:0] reqTarget,
  input  logic [ARB_NUM_IN*ARB_SLOTS*ARB_AGE_W-1:0] reqAge,
  input  logic [ARB_NUM_IN*ARB_SLOTS*ARB_SLOT_W-1:0] locOrder,
  input  logic [ARB_NUM_OUT*ARB_NUM_IN*ARB_IN_W-1:0] gloOrder,
  output logic [ARB_NUM_OUT*ARB_NUM_IN-1:0]         grant,
  output logic [ARB_NUM_IN*ARB_SLOTS-1:0]           slotAccept,
  output arb_strobe_t                               strobe
);
  logic                  nomValid  [ARB_NUM_IN];
  logic [ARB_SLOT_W-1:0] nomSlot   [ARB_NUM_IN];
  logic [ARB_OUT_W-1:0]  nomTarget [ARB_NUM_IN];
  logic [ARB_KEY_W-1:0]  nomAgeKey [ARB_NUM_IN];
  logic [ARB_KEY_W-1:0]  nomClsKey [ARB_NUM_IN];
  logic                  winValid  [ARB_NUM_OUT];
  logic [ARB_IN_W-1:0]   winIdx    [ARB_NUM_OUT];
  logic [ARB_NUM_IN-1:0] inputWon;

  // First stage: earliest valid slot in each input's list
  always_comb begin
    for (int i = 0; i < ARB_NUM_IN; i++) begin
      int base;
      nomValid[i] = 1'b0;
      nomSlot[i]  = '0;
      for (int p = ARB_SLOTS - 1; p >= 0; p--) begin
        logic [ARB_SLOT_W-1:0] s;
        s = locOrder[(i*ARB_SLOTS + p)*ARB_SLOT_W +: ARB_SLOT_W];
        if (reqValid[i*ARB_SLOTS + int'(s)]) begin
          nomValid[i] = 1'b1;
          nomSlot[i]  = s;
        end
      end
      base = i*ARB_SLOTS + int'(nomSlot[i]);
      nomTarget[i] = reqTarget[base*ARB_OUT_W +: ARB_OUT_W];
      nomAgeKey[i] = ARB_KEY_W'(reqAge[base*ARB_AGE_W +: ARB_AGE_W]);
      nomClsKey[i] = ARB_KEY_W'(int'(nomSlot[i]) / ARB_NUM_VC);
    end
  end

  // Second stage: best key per output, ties to earliest in the output list
  always_comb begin
    for (int o = 0; o < ARB_NUM_OUT; o++) begin
      logic                 found;
      logic [ARB_KEY_W-1:0] bestKey;
      logic [ARB_IN_W-1:0]  bestIdx;
      found   = 1'b0;
      bestKey = '0;
      bestIdx = '0;
      for (int p = 0; p < ARB_NUM_IN; p++) begin
        logic [ARB_IN_W-1:0]  idx;
        logic [ARB_KEY_W-1:0] key;
        idx = gloOrder[(o*ARB_NUM_IN + p)*ARB_IN_W +: ARB_IN_W];
        key = (mode == ARB_CLASS) ? nomClsKey[idx] : nomAgeKey[idx];
        if (nomValid[idx] && nomTarget[idx] == ARB_OUT_W'(o) &&
            (!found || key > bestKey)) begin
          found   = 1'b1;
          bestKey = key;
          bestIdx = idx;
        end
      end
      winValid[o] = found;
      winIdx[o]   = bestIdx;
    end
  end

  always_comb begin
    grant      = '0;
    slotAccept = '0;
    inputWon   = '0;
    for (int o = 0; o < ARB_NUM_OUT; o++) begin
      if (winValid[o]) begin
        grant[o*ARB_NUM_IN + int'(winIdx[o])] = 1'b1;
        inputWon[winIdx[o]] = 1'b1;
      end
    end
    for (int i = 0; i < ARB_NUM_IN; i++) begin
      if (inputWon[i]) slotAccept[i*ARB_SLOTS + int'(nomSlot[i])] = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < ARB_NUM_IN; i++) begin
      strobe.locUpd[i]  = inputWon[i];
      strobe.locSlot[i] = nomSlot[i];
    end
    for (int o = 0; o < ARB_NUM_OUT; o++) begin
      strobe.gloUpd[o] = winValid[o];
      strobe.gloIdx[o] = winIdx[o];
    end
  end

  for (genvar o = 0; o < ARB_NUM_OUT; o++) begin : g_ast_out
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grant[o*ARB_NUM_IN +: ARB_NUM_IN])); // R7
  end

  for (genvar i = 0; i < ARB_NUM_IN; i++) begin : g_ast_in
    logic [ARB_NUM_OUT-1:0] grantCol;
    for (genvar o = 0; o < ARB_NUM_OUT; o++) begin : g_col
      assign grantCol[o] = grant[o*ARB_NUM_IN + i];
    end
    AST_INPUT_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grantCol)); // R8
    AST_ACCEPT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(slotAccept[i*ARB_SLOTS +: ARB_SLOTS])); // R8
  end

  AST_ACCEPT_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (slotAccept & ~reqValid) == '0); // R8
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid == '0) |-> (grant == '0 && slotAccept == '0)); // R9
endmodule

// File: rtl/router_arb_top.sv
module router_arb_top
  import router_arb_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic mode,
  input  logic [ARB_NUM_IN*ARB_SLOTS-1:0]           reqValid,
  input  logic [ARB_NUM_IN*ARB_SLOTS*ARB_OUT_W-1:0] reqTarget,
  input  logic [ARB_NUM_IN*ARB_SLOTS*ARB_AGE_W-1:0] reqAge,
  output logic [ARB_NUM_OUT*ARB_NUM_IN-1:0]         grant,
  output logic [ARB_NUM_IN*ARB_SLOTS-1:0]           slotAccept
);
  arb_strobe_t strobe;
  logic [ARB_NUM_IN*ARB_SLOTS*ARB_SLOT_W-1:0] locOrder;
  logic [ARB_NUM_OUT*ARB_NUM_IN*ARB_IN_W-1:0] gloOrder;

  router_arb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .mode(mode),
    .reqValid(reqValid), .reqTarget(reqTarget), .reqAge(reqAge),
    .locOrder(locOrder), .gloOrder(gloOrder),
    .grant(grant), .slotAccept(slotAccept), .strobe(strobe)
  );

  router_arb_store store_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .locOrder(locOrder), .gloOrder(gloOrder)
  );
endmodule

// File: tb/router_arb_top_tb_top.sv
`timescale 1ns/1ps
module router_arb_top_tb_top;
  import router_arb_pkg::*;
  localparam int NI = ARB_NUM_IN;
  localparam int NO = ARB_NUM_OUT;
  localparam int S  = ARB_SLOTS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mode = 1'b0;
  logic [NI*S-1:0]           vValid = '0;
  logic [NI*S*ARB_OUT_W-1:0] vTarget = '0;
  logic [NI*S*ARB_AGE_W-1:0] vAge = '0;
  logic [NO*NI-1:0] grant;
  logic [NI*S-1:0]  slotAccept;

  always #2 clk = ~clk;

  router_arb_top dut_i (
    .clk(clk), .rstN(rstN), .mode(mode),
    .reqValid(vValid), .reqTarget(vTarget), .reqAge(vAge),
    .grant(grant), .slotAccept(slotAccept)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int locQ [NI][$];
  int gloQ [NO][$];
  int nomS [NI];
  int winI [NO];
  logic [NO*NI-1:0] expGrant;
  logic [NI*S-1:0]  expAccept;

  task automatic modelReset();
    for (int i = 0; i < NI; i++) begin
      locQ[i] = {};
      for (int s = 0; s < S; s++) locQ[i].push_back(s);
    end
    for (int o = 0; o < NO; o++) begin
      gloQ[o] = {};
      for (int i = 0; i < NI; i++) gloQ[o].push_back(i);
    end
  endtask

  task automatic computeExp();
    expGrant = '0;
    expAccept = '0;
    for (int i = 0; i < NI; i++) begin
      nomS[i] = -1;
      foreach (locQ[i][k]) begin
        if (nomS[i] < 0 && vValid[i*S + locQ[i][k]]) nomS[i] = locQ[i][k];
      end
    end
    for (int o = 0; o < NO; o++) begin
      int bestKey;
      winI[o] = -1;
      bestKey = -1;
      foreach (gloQ[o][k]) begin
        int idx, key, b;
        idx = gloQ[o][k];
        if (nomS[idx] >= 0) begin
          b = idx*S + nomS[idx];
          if (int'(vTarget[b*ARB_OUT_W +: ARB_OUT_W]) == o) begin
            key = mode ? nomS[idx] / ARB_NUM_VC : int'(vAge[b*ARB_AGE_W +: ARB_AGE_W]);
            if (key > bestKey) begin
              bestKey = key;
              winI[o] = idx;
            end
          end
        end
      end
      if (winI[o] >= 0) begin
        expGrant[o*NI + winI[o]] = 1'b1;
        expAccept[winI[o]*S + nomS[winI[o]]] = 1'b1;
      end
    end
  endtask

  task automatic moveToEnd(ref int q[$], input int v);
    for (int k = 0; k < q.size(); k++) begin
      if (q[k] == v) begin
        q.delete(k);
        break;
      end
    end
    q.push_back(v);
  endtask

  task automatic modelUpdate();
    for (int o = 0; o < NO; o++) begin
      if (winI[o] >= 0) begin
        moveToEnd(gloQ[o], winI[o]);
        moveToEnd(locQ[winI[o]], nomS[winI[o]]);
      end
    end
  endtask

  task automatic check(string tag, logic [1023:0] act, logic [1023:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    int colMax, rowMax;
    check(tag, 1024'(grant), 1024'(expGrant), "grant");
    check(tag, 1024'(slotAccept), 1024'(expAccept), "slotAccept");
    rowMax = 0;
    for (int o = 0; o < NO; o++) begin
      int c = 0;
      for (int i = 0; i < NI; i++) c += int'(grant[o*NI+i]);
      if (c > rowMax) rowMax = c;
    end
    check("R7", 1024'(rowMax > 1), 1024'(0), "output with several grants");
    colMax = 0;
    for (int i = 0; i < NI; i++) begin
      int c = 0;
      for (int o = 0; o < NO; o++) c += int'(grant[o*NI+i]);
      if (c > colMax) colMax = c;
    end
    check("R8", 1024'(colMax > 1), 1024'(0), "input with several grants");
  endtask

  function automatic void randStim(int density, bit sameAge);
    for (int b = 0; b < NI*S; b++) begin
      vValid[b] = ($urandom_range(0, density) == 0);
      vTarget[b*ARB_OUT_W +: ARB_OUT_W] = ARB_OUT_W'($urandom_range(0, NO-1));
      vAge[b*ARB_AGE_W +: ARB_AGE_W] = sameAge ? ARB_AGE_W'(5) : ARB_AGE_W'($urandom);
    end
  endfunction

  task automatic step(string tag);
    #1;
    computeExp();
    compareAll(tag);
    modelUpdate();
    @(negedge clk);
  endtask

  initial begin
    modelReset();
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R1", 1024'(grant), 1024'(0), "grant in reset");
    // R1: first cycle after reset, everything valid, equal ages
    for (int b = 0; b < NI*S; b++) begin
      vValid[b] = 1'b1;
      vTarget[b*ARB_OUT_W +: ARB_OUT_W] = ARB_OUT_W'((b / S) % NO);
      vAge[b*ARB_AGE_W +: ARB_AGE_W] = '0;
    end
    @(negedge clk);
    rstN = 1'b1;
    step("R1");
    // R2: full load held steady, lists rotate
    for (int c = 0; c < 40; c++) step("R2");
    // R4: age mode, random traffic
    mode = 1'b0;
    for (int c = 0; c < 300; c++) begin randStim(2, 1'b0); step("R4"); end
    // R5: class mode, random traffic
    mode = 1'b1;
    for (int c = 0; c < 300; c++) begin randStim(2, 1'b0); step("R5"); end
    // R6: equal ages force list tie-breaks
    mode = 1'b0;
    for (int c = 0; c < 200; c++) begin randStim(1, 1'b1); step("R6"); end
    mode = 1'b1;
    for (int c = 0; c < 100; c++) begin randStim(1, 1'b1); step("R6"); end
    // R3: requests persist until accepted, losers retry
    vValid = '0;
    for (int c = 0; c < 400; c++) begin
      #1;
      computeExp();
      compareAll("R3");
      modelUpdate();
      @(negedge clk);
      mode = (c % 100) >= 50;
      vValid = vValid & ~expAccept;
      for (int b = 0; b < NI*S; b++) begin
        if (!vValid[b] && $urandom_range(0, 15) == 0) begin
          vValid[b] = 1'b1;
          vTarget[b*ARB_OUT_W +: ARB_OUT_W] = ARB_OUT_W'($urandom_range(0, NO-1));
          vAge[b*ARB_AGE_W +: ARB_AGE_W] = ARB_AGE_W'($urandom);
        end
      end
    end
    // R9: idle, then traffic shows lists untouched
    vValid = '0;
    for (int c = 0; c < 10; c++) step("R9");
    randStim(1, 1'b1);
    for (int c = 0; c < 5; c++) step("R9");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule